// File: doc/BRIEF.md
# Two-Wire Serial Bus Mode Controller

This block holds the operating mode of a two-wire serial bus interface that can also run a clocked synchronous serial format. A CPU writes a control byte with four live bits: interface enable, receive inhibit, master select and transmit select. The combination of master and transmit selects one of four modes. The block also changes the mode by itself when the bit engine reports certain bus events: arbitration loss, overrun, or a received address byte that matches the programmed slave address.

From the control bits it drives two signals. One enables the bus pins. The other enables the serial clock output. It also tells the shifter, with a one-cycle pulse, when a read of the received-data register may start the next reception. The bit-level protocol, the shift register and the baud generation sit outside the block. They reach it only through event strobes, the captured address byte and the data-register read strobe.

Top module: `sbus_mode_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all four control bits are 0. `cfg_rdata` is 0x00, `mode` is 00, and `pin_en` and `scl_oe` are both 0.
- R2: A write with `cfg_wr` high loads the control bits from `cfg_wdata`: enable from bit 7, receive inhibit from bit 6, master from bit 5 and transmit from bit 4. One clock after the bits change, `cfg_rdata` shows them in the same positions, with bits 3..0 read as 0.
- R3: `mode` is {master, transmit}: 00 is slave receive, 01 is slave transmit, 10 is master receive and 11 is master transmit.
- R4: `pin_en` equals the enable bit. When it is 0, the bus pins are released to port use.
- R5: `scl_oe` is 1 exactly when enable is 1, `sync_fmt` is 1 (clocked synchronous format) and master is 1.
- R6: Suppose enable is 1, master is 1 and `sync_fmt` is 0. Then an `ev_arb_lost` strobe clears both master and transmit on the next edge.
- R7: Suppose enable is 1, master is 1 and `sync_fmt` is 1. Then an `ev_overrun` strobe clears master on the next edge and leaves transmit unchanged.
- R8: Suppose enable is 1 and the mode is slave receive when `ev_addr_done` is strobed. If `rx_addr_byte[7:1]` equals `own_addr` and `rx_addr_byte[0]` is 1, transmit is set to 1 and `addr_match` pulses for one cycle after the edge.
- R9: A matching address with `rx_addr_byte[0]` equal to 0 pulses `addr_match` and leaves transmit at 0.
- R10: An address whose upper seven bits differ from `own_addr` gives no pulse and no mode change. So does an address received outside slave receive mode.
- R11: A `rdr_read` strobe while enable is 1 and transmit is 0 gives a one-cycle `rx_resume` pulse after the edge, but only if receive inhibit is 0. Otherwise no pulse is given.
- R12: When a mode-changing hardware event (R6, R7 or R8) and a CPU write occur in the same cycle, the event decides master and transmit and the write's bits 5 and 4 are discarded. The enable and receive-inhibit fields of that write still load.
- R13: While enable is 0, arbitration-loss, overrun and address strobes change no bit and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Registered control byte read-back |
| sync_fmt | input | 1 | 1 selects the clocked synchronous format, 0 the two-wire format |
| own_addr | input | 7 | Programmed slave address |
| ev_arb_lost | input | 1 | Arbitration-loss strobe from the bus controller |
| ev_overrun | input | 1 | Overrun strobe from the shifter |
| ev_addr_done | input | 1 | Address byte received strobe |
| rx_addr_byte | input | 8 | Received address byte; bits 7..1 are the address, bit 0 the direction |
| rdr_read | input | 1 | Read strobe of the received-data register |
| mode | output | 2 | Current {master, transmit} mode |
| pin_en | output | 1 | Bus pins driven by the interface |
| scl_oe | output | 1 | Serial clock output enable |
| addr_match | output | 1 | One-cycle address match pulse |
| rx_resume | output | 1 | One-cycle permission to start the next reception |

## Verification
The embedded assertions check several things on every cycle:
- arbitration loss always lands in slave receive mode, and an overrun clears master without touching transmit;
- a qualified read-type address match always leaves transmit set;
- a halted block holds its mode bits when no write occurs;
- the clock output is never enabled without the pins enabled;
- a reception permission pulse always follows a data-register read.

Some behaviours only the bench's sweep can show, because they need the expected values worked out per case. These are the exact read-back byte and its one-cycle lag, the rejection of mismatching or mis-moded addresses, the receive-inhibit gating, and the priority of events over a same-cycle write. The sweep covers every control nibble under both formats and every event kind.

// File: rtl/sbus_mode_pkg.sv
// Package: shared types and bit positions for the serial bus mode controller.
// Assumes an 8-bit control byte with the four live bits at the top.
package sbus_mode_pkg;
    localparam int CTL_W  = 8;
    localparam int EN_POS = CTL_W - 1;
    localparam int RD_POS = CTL_W - 2;
    localparam int MS_POS = CTL_W - 3;
    localparam int TX_POS = CTL_W - 4;

    typedef enum logic [1:0] {
        MODE_SLV_RX = 2'b00,
        MODE_SLV_TX = 2'b01,
        MODE_MST_RX = 2'b10,
        MODE_MST_TX = 2'b11
    } bus_mode_e;

    typedef struct packed {
        logic en;
        logic rx_inh;
        logic mst;
        logic tx;
    } ctl_bits_t;
endpackage

// File: rtl/sbus_evt_qual.sv
// Event qualifier: decides which bus event strobes act on the current state.
// Assumes the strobes are single-cycle and synchronous to clk.
// Purely combinational.
module sbus_evt_qual
    import sbus_mode_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  ctl_bits_t         ctl,
    input  logic              sync_fmt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ev_arb_lost,
    input  logic              ev_overrun,
    input  logic              ev_addr_done,
    input  logic [ADDR_W:0]   rx_addr_byte,
    output logic              hit_arb,
    output logic              hit_ovr,
    output logic              hit_addr,
    output logic              hit_addr_rd
);
    logic slave_rx;

    // Qualify each strobe against enable, mode and format.
    always_comb begin
        slave_rx    = ctl.en && !ctl.mst && !ctl.tx;
        hit_arb     = ctl.en && ctl.mst && !sync_fmt && ev_arb_lost;
        hit_ovr     = ctl.en && ctl.mst && sync_fmt && ev_overrun;
        hit_addr    = slave_rx && ev_addr_done && (rx_addr_byte[ADDR_W:1] == own_addr);
        hit_addr_rd = hit_addr && rx_addr_byte[0];
    end
endmodule

// File: rtl/sbus_ctl_regs.sv
// Control register: holds the four mode bits and applies CPU writes and hardware events.
// Hardware events win over a same-cycle write for the master/transmit bits.
// Also produces a registered read-back byte.
module sbus_ctl_regs
    import sbus_mode_pkg::*;
#(
    parameter int DATA_W = CTL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              sync_fmt,
    input  logic              hit_arb,
    input  logic              hit_ovr,
    input  logic              hit_addr_rd,
    output ctl_bits_t         ctl_q,
    output logic [DATA_W-1:0] cfg_rdata
);
    localparam int PAD_W = DATA_W - 4;

    ctl_bits_t ctl_d;

    // Next-state selection: write first, then hardware overrides on mode bits.
    always_comb begin
        ctl_d = ctl_q;
        if (cfg_wr) begin
            ctl_d.en     = cfg_wdata[EN_POS];
            ctl_d.rx_inh = cfg_wdata[RD_POS];
            ctl_d.mst    = cfg_wdata[MS_POS];
            ctl_d.tx     = cfg_wdata[TX_POS];
        end
        if (hit_arb) begin
            ctl_d.mst = 1'b0;
            ctl_d.tx  = 1'b0;
        end else if (hit_ovr) begin
            ctl_d.mst = 1'b0;
            ctl_d.tx  = ctl_q.tx;
        end else if (hit_addr_rd) begin
            ctl_d.mst = ctl_q.mst;
            ctl_d.tx  = 1'b1;
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Registered read-back of the live bits, low bits zero.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_rdata <= '0;
        else        cfg_rdata <= {ctl_q.en, ctl_q.rx_inh, ctl_q.mst, ctl_q.tx, {PAD_W{1'b0}}};
    end

    assert_arb_to_slave_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_arb |=> (!ctl_q.mst && !ctl_q.tx));

    assert_ovr_keeps_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ovr |=> (!ctl_q.mst && ctl_q.tx == $past(ctl_q.tx)));

    assert_addr_sets_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_addr_rd |=> ctl_q.tx);

    assert_halt_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.en && !cfg_wr) |=> ($stable(ctl_q.mst) && $stable(ctl_q.tx)));

    assert_sync_no_arb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_fmt |-> !hit_arb);
endmodule

// File: rtl/sbus_pulse_gen.sv
// Pulse generator: registers the address-match and reception-permission pulses.
// Assumes rdr_read is a single-cycle strobe.
module sbus_pulse_gen
    import sbus_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ctl_bits_t ctl_q,
    input  logic      hit_addr,
    input  logic      rdr_read,
    output logic      addr_match,
    output logic      rx_resume
);
    // One-cycle pulses derived from the pre-edge state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_match <= 1'b0;
            rx_resume  <= 1'b0;
        end else begin
            addr_match <= hit_addr;
            rx_resume  <= rdr_read && ctl_q.en && !ctl_q.tx && !ctl_q.rx_inh;
        end
    end

    assert_resume_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_resume |-> $past(rdr_read));
endmodule

// File: rtl/sbus_pin_ctrl.sv
// Pin control: derives the pin enable, the clock output enable and the mode code.
// Combinational from the control bits and the format select.
module sbus_pin_ctrl
    import sbus_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ctl_bits_t ctl_q,
    input  logic      sync_fmt,
    output logic      pin_en,
    output logic      scl_oe,
    output logic [1:0] mode
);
    bus_mode_e mode_e;

    // Decode pin drive and mode from the register state.
    always_comb begin
        pin_en = ctl_q.en;
        scl_oe = ctl_q.en && sync_fmt && ctl_q.mst;
        mode_e = bus_mode_e'({ctl_q.mst, ctl_q.tx});
        mode   = mode_e;
    end

    assert_clk_needs_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> (pin_en && mode[1]));
endmodule

// File: rtl/sbus_mode_ctrl.sv
// Top: serial bus mode controller. Joins the event qualifier, the control register,
// the pulse generator and the pin control. Assumes all inputs are synchronous to clk.
module sbus_mode_ctrl
    import sbus_mode_pkg::*;
#(
    parameter int DATA_W = CTL_W,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              sync_fmt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ev_arb_lost,
    input  logic              ev_overrun,
    input  logic              ev_addr_done,
    input  logic [ADDR_W:0]   rx_addr_byte,
    input  logic              rdr_read,
    output logic [1:0]        mode,
    output logic              pin_en,
    output logic              scl_oe,
    output logic              addr_match,
    output logic              rx_resume
);
    ctl_bits_t ctl_q;
    logic hit_arb, hit_ovr, hit_addr, hit_addr_rd;

    sbus_evt_qual #(.ADDR_W(ADDR_W)) u_qual (
        .ctl(ctl_q), .sync_fmt(sync_fmt), .own_addr(own_addr),
        .ev_arb_lost(ev_arb_lost), .ev_overrun(ev_overrun),
        .ev_addr_done(ev_addr_done), .rx_addr_byte(rx_addr_byte),
        .hit_arb(hit_arb), .hit_ovr(hit_ovr),
        .hit_addr(hit_addr), .hit_addr_rd(hit_addr_rd)
    );

    sbus_ctl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .sync_fmt(sync_fmt), .hit_arb(hit_arb), .hit_ovr(hit_ovr),
        .hit_addr_rd(hit_addr_rd), .ctl_q(ctl_q), .cfg_rdata(cfg_rdata)
    );

    sbus_pulse_gen u_pulse (
        .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .hit_addr(hit_addr),
        .rdr_read(rdr_read), .addr_match(addr_match), .rx_resume(rx_resume)
    );

    sbus_pin_ctrl u_pins (
        .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .sync_fmt(sync_fmt),
        .pin_en(pin_en), .scl_oe(scl_oe), .mode(mode)
    );
endmodule

// File: tb/sim_sbus_mode_ctrl.sv
module sim_sbus_mode_ctrl;
    localparam logic [6:0] OWN = 7'h5B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       sync_fmt = 1'b0;
    logic       ev_arb_lost = 1'b0, ev_overrun = 1'b0, ev_addr_done = 1'b0, rdr_read = 1'b0;
    logic [7:0] rx_addr_byte = '0;
    logic [1:0] mode;
    logic       pin_en, scl_oe, addr_match, rx_resume;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model state
    logic m_en = 0, m_inh = 0, m_mst = 0, m_tx = 0;
    logic e_am = 0, e_rr = 0;
    logic [7:0] e_rd = '0;

    always #10 clk = ~clk;

    sbus_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sync_fmt(sync_fmt), .own_addr(OWN),
        .ev_arb_lost(ev_arb_lost), .ev_overrun(ev_overrun),
        .ev_addr_done(ev_addr_done), .rx_addr_byte(rx_addr_byte),
        .rdr_read(rdr_read), .mode(mode), .pin_en(pin_en), .scl_oe(scl_oe),
        .addr_match(addr_match), .rx_resume(rx_resume)
    );

    task automatic chk(input string what, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        chk("mode", tag, {6'b0, mode}, {6'b0, m_mst, m_tx});
        chk("pin_en", "R4", {7'b0, pin_en}, {7'b0, m_en});
        chk("scl_oe", "R5", {7'b0, scl_oe}, {7'b0, m_en & sync_fmt & m_mst});
        chk("cfg_rdata", "R2", cfg_rdata, e_rd);
        chk("addr_match", tag, {7'b0, addr_match}, {7'b0, e_am});
        chk("rx_resume", tag, {7'b0, rx_resume}, {7'b0, e_rr});
    endtask

    task automatic apply(input logic wr, input logic [7:0] wd, input logic arb, input logic ovr,
                         input logic ad, input logic [7:0] ab, input logic rrd, input string tag);
        logic h_arb, h_ovr, h_m, match;
        logic n_en, n_inh, n_mst, n_tx;
        @(negedge clk);
        cfg_wr = wr; cfg_wdata = wd; ev_arb_lost = arb; ev_overrun = ovr;
        ev_addr_done = ad; rx_addr_byte = ab; rdr_read = rrd;
        h_arb = m_en & m_mst & ~sync_fmt & arb;
        h_ovr = m_en & m_mst & sync_fmt & ovr;
        match = m_en & ~m_mst & ~m_tx & ad & (ab[7:1] == OWN);
        h_m   = match & ab[0];
        n_en  = wr ? wd[7] : m_en;
        n_inh = wr ? wd[6] : m_inh;
        n_mst = wr ? wd[5] : m_mst;
        n_tx  = wr ? wd[4] : m_tx;
        if (h_arb) begin n_mst = 0; n_tx = 0; end
        else if (h_ovr) begin n_mst = 0; n_tx = m_tx; end
        else if (h_m) begin n_mst = m_mst; n_tx = 1; end
        e_am = match;
        e_rr = rrd & m_en & ~m_tx & ~m_inh;
        e_rd = {m_en, m_inh, m_mst, m_tx, 4'b0};
        @(posedge clk);
        #5;
        m_en = n_en; m_inh = n_inh; m_mst = n_mst; m_tx = n_tx;
        compare_all(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R1 reset state
        chk("mode", "R1", {6'b0, mode}, 8'h00);
        chk("cfg_rdata", "R1", cfg_rdata, 8'h00);
        chk("pin_en", "R1", {7'b0, pin_en}, 8'h00);
        chk("scl_oe", "R1", {7'b0, scl_oe}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        for (int w = 0; w < 16; w++) begin
            for (int s = 0; s < 2; s++) begin
                for (int e = 0; e < 9; e++) begin
                    string tg;
                    logic [7:0] wv;
                    wv = {w[3:0], 4'b0};
                    @(negedge clk);
                    sync_fmt = s[0];
                    apply(1, wv, 0, 0, 0, 8'h00, 0, "R2");
                    case (e)
                        0: tg = "R3";
                        1: tg = "R6";
                        2: tg = "R7";
                        3: tg = "R8";
                        4: tg = "R9";
                        5: tg = "R10";
                        6: tg = "R11";
                        default: tg = "R12";
                    endcase
                    if (!w[3] && e >= 1 && e <= 5) tg = "R13";
                    case (e)
                        0: apply(0, 0, 0, 0, 0, 8'h00, 0, tg);
                        1: apply(0, 0, 1, 0, 0, 8'h00, 0, tg);
                        2: apply(0, 0, 0, 1, 0, 8'h00, 0, tg);
                        3: apply(0, 0, 0, 0, 1, {OWN, 1'b1}, 0, tg);
                        4: apply(0, 0, 0, 0, 1, {OWN, 1'b0}, 0, tg);
                        5: apply(0, 0, 0, 0, 1, {OWN ^ 7'h01, 1'b1}, 0, tg);
                        6: apply(0, 0, 0, 0, 0, 8'h00, 1, tg);
                        7: apply(1, 8'hF0, 1, 1, 0, 8'h00, 0, tg);
                        default: apply(1, 8'hA0, 0, 0, 1, {OWN, 1'b1}, 0, tg);
                    endcase
                    apply(0, 0, 0, 0, 0, 8'h00, 0, "R3");
                end
            end
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            fails++;
            $display("FAIL timeout R1 actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule